// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of general-purpose pins, 32 wide by default, with a small word-wide register bus. Each pin is set to be either an input or an output. An output drives a stored value. If its blink bit is set, that value is gated by a free-running square wave.

An input is first resynchronised into the clock domain. It then passes through a per-pin polarity inverter. The corrected value is visible on the bus and feeds two interrupt paths: a level path gated by a level mask, and a sticky rising-edge latch gated by an edge mask.

Because the inverter sits ahead of both paths, software chooses the active level or edge by programming polarity. Flipping polarity after every event lets software follow both edges of a line. The enabled requests of every eight adjacent pins are ORed into one interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones (every pin is an input) and `pad_oe` is 0. The drive, blink, polarity, edge-latch and both mask registers read 0, and every `irq` line is low.
- R2: Word offsets are: drive 0x00, direction 0x04, blink 0x08, polarity 0x0C, sensed input 0x10, edge latch 0x14, edge enable 0x18, level enable 0x1C. The drive, direction, blink, polarity and both enable registers read back what was written. The sensed input register ignores writes. Any other offset reads 0 and its writes change no register.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pad_oe` is the inverse of the direction register from the cycle after the write. For a pin whose blink bit is 0, `pad_out` equals its drive bit.
- R4: The sensed input register reads `pad_in` XOR polarity. A pad change made between two clock edges is visible after the second following edge, and not after the first.
- R5: An edge latch bit is set when the pin's corrected input goes from 0 to 1. Polarity 0 therefore catches rising pad edges, and polarity 1 catches falling pad edges. A bit that is set stays set until software clears it.
- R6: Writing the edge latch register clears each bit written 0 and keeps each bit written 1. A new edge arriving in the same cycle as a clear leaves the bit set.
- R7: The request of a pin is (corrected input AND level enable) OR (edge latch AND edge enable).
- R8: `irq[g]` is the OR of the requests of pins 8g to 8g+7.
- R9: For an output pin with its blink bit set, `pad_out` is its drive bit ANDed with a square wave. The wave is high for BLINK_HALF cycles and then low for BLINK_HALF cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata | input | PINS (32) | Write data |
| bus_rdata | output | PINS (32) | Read data, combinational from `bus_addr` |
| pad_in | input | PINS (32) | Asynchronous pad inputs |
| pad_out | output | PINS (32) | Pad output values |
| pad_oe | output | PINS (32) | Pad output enables, 1 = drive |
| irq | output | PINS/GROUP (4) | Grouped interrupt requests |

## Verification
A register write takes effect at the edge that samples the strobe, so readback and `pad_oe` are checked at the next falling edge. A pad change appears in the sensed register two edges later, and in the edge latch and `irq` three edges later. The bench therefore waits at least four falling edges after each pad change before it samples. It also probes the exact second edge for R4, and it lines up a latch clear with the third edge to exercise R6. Blink timing is measured by counting falling-edge samples between transitions of the pin, so the check does not depend on when the wave started.

// File: rtl/gpio_bank_pkg.sv
// Shared register offsets of the GPIO bank.
// Assumes word-aligned byte offsets; any other offset is unmapped.
package gpio_bank_pkg;
    localparam int OFS_DRIVE    = 'h00;
    localparam int OFS_DIR      = 'h04;
    localparam int OFS_FLASH    = 'h08;
    localparam int OFS_INVERT   = 'h0C;
    localparam int OFS_SENSE    = 'h10;
    localparam int OFS_LATCH    = 'h14;
    localparam int OFS_LATCH_EN = 'h18;
    localparam int OFS_LEVEL_EN = 'h1C;
endpackage

// File: rtl/gpio_in_path.sv
// Input path: two-flop synchroniser, polarity XOR, rising-edge detect.
// Assumes pad_in is asynchronous; rise is a one-cycle pulse per pin.
module gpio_in_path #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_in,
    input  logic [PINS-1:0] invert,
    output logic [PINS-1:0] sense,
    output logic [PINS-1:0] rise
);
    logic [PINS-1:0] meta_q, sync_q, prev_q;

    // Resynchronise pads and remember the previous corrected value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sense;
        end
    end

    // Apply polarity and flag corrected 0-to-1 transitions.
    always_comb begin
        sense = sync_q ^ invert;
        rise  = sense & ~prev_q;
    end
endmodule

// File: rtl/gpio_blink_gen.sv
// Free-running square wave, high and low for HALF cycles each.
// Assumes HALF >= 1; the wave starts low after reset.
module gpio_blink_gen #(
    parameter int HALF = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Count HALF cycles and flip the wave at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wave  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            wave  <= ~wave;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WAVE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wave != $past(wave)) |-> ($past(cnt_q) == LAST)); // R9
endmodule

// File: rtl/gpio_irq_combine.sv
// Per-pin request = level path | edge path; OR-reduced per group of pins.
// Assumes PINS is a multiple of GROUP.
module gpio_irq_combine #(
    parameter int PINS  = 32,
    parameter int GROUP = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PINS-1:0]       sense,
    input  logic [PINS-1:0]       level_en,
    input  logic [PINS-1:0]       latch,
    input  logic [PINS-1:0]       latch_en,
    output logic [PINS/GROUP-1:0] irq
);
    localparam int NGRP = PINS / GROUP;

    logic [PINS-1:0] req;

    // Merge level and edge requests per pin.
    always_comb req = (sense & level_en) | (latch & latch_en);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // OR the requests of one group onto its line.
        always_comb irq[g] = |req[g*GROUP +: GROUP];
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((level_en | latch_en) == '0) |-> (irq == '0)); // R8
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: register file, output drive with blink, edge latch,
// read mux. Assumes single-cycle writes and combinational reads.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS       = 32,
    parameter int GROUP      = 8,
    parameter int BLINK_HALF = 6,
    parameter int ADDR_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [PINS-1:0]       bus_wdata,
    output logic [PINS-1:0]       bus_rdata,
    input  logic [PINS-1:0]       pad_in,
    output logic [PINS-1:0]       pad_out,
    output logic [PINS-1:0]       pad_oe,
    output logic [PINS/GROUP-1:0] irq
);
    logic [PINS-1:0] drive_q, dir_q, flash_q, invert_q;
    logic [PINS-1:0] latch_q, latch_en_q, level_en_q;
    logic [PINS-1:0] sense, rise;
    logic            wave;
    logic            wr_latch;

    // Decode the edge latch write strobe.
    always_comb wr_latch = bus_wr && (bus_addr == ADDR_W'(OFS_LATCH));

    // Configuration registers, written whole-word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q    <= '0;
            dir_q      <= '1;
            flash_q    <= '0;
            invert_q   <= '0;
            latch_en_q <= '0;
            level_en_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_DRIVE):    drive_q    <= bus_wdata;
                ADDR_W'(OFS_DIR):      dir_q      <= bus_wdata;
                ADDR_W'(OFS_FLASH):    flash_q    <= bus_wdata;
                ADDR_W'(OFS_INVERT):   invert_q   <= bus_wdata;
                ADDR_W'(OFS_LATCH_EN): latch_en_q <= bus_wdata;
                ADDR_W'(OFS_LEVEL_EN): level_en_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Sticky edge latch: write-0 clears, a new edge wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & (wr_latch ? bus_wdata : '1)) | rise;
    end

    // Pad drive: blink-gated outputs, enables are the inverted direction.
    always_comb begin
        pad_oe  = ~dir_q;
        pad_out = drive_q & (~flash_q | {PINS{wave}});
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DRIVE):    bus_rdata = drive_q;
            ADDR_W'(OFS_DIR):      bus_rdata = dir_q;
            ADDR_W'(OFS_FLASH):    bus_rdata = flash_q;
            ADDR_W'(OFS_INVERT):   bus_rdata = invert_q;
            ADDR_W'(OFS_SENSE):    bus_rdata = sense;
            ADDR_W'(OFS_LATCH):    bus_rdata = latch_q;
            ADDR_W'(OFS_LATCH_EN): bus_rdata = latch_en_q;
            ADDR_W'(OFS_LEVEL_EN): bus_rdata = level_en_q;
            default:               bus_rdata = '0;
        endcase
    end

    gpio_in_path #(.PINS(PINS)) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .invert(invert_q),
        .sense(sense), .rise(rise));

    gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
        .clk(clk), .rst_n(rst_n), .wave(wave));

    gpio_irq_combine #(.PINS(PINS), .GROUP(GROUP)) u_irq (
        .clk(clk), .rst_n(rst_n), .sense(sense), .level_en(level_en_q),
        .latch(latch_q), .latch_en(latch_en_q), .irq(irq));

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == ~$past(bus_wdata))); // R3
    AST_SENSE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_SENSE)) |=>
        ($stable(drive_q) && $stable(dir_q) && $stable(invert_q) && $stable(flash_q))); // R2
    AST_LATCH_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(rise)) == '0)); // R5
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise) & ~latch_q) == '0)); // R6
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
    localparam int PINS = 32, GROUP = 8, HALF = 6, AW = 6, NGRP = PINS / GROUP;
    localparam logic [AW-1:0] A_DRV = 6'h00, A_DIR = 6'h04, A_FLS = 6'h08,
        A_INV = 6'h0C, A_SEN = 6'h10, A_LAT = 6'h14, A_LEN = 6'h18, A_VEN = 6'h1C;

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [PINS-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
    logic [NGRP-1:0] irq;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.PINS(PINS), .GROUP(GROUP), .BLINK_HALF(HALF), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

    function automatic logic [NGRP-1:0] grp_or(input logic [PINS-1:0] v);
        for (int g = 0; g < NGRP; g++) grp_or[g] = |v[g*GROUP +: GROUP];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [PINS-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [PINS-1:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [PINS-1:0] d, p, a, b, m, l, exp, f;
        int hi, lo;
        void'($urandom(32'h5eed_0042));
        wait_n(4); rst_n = 1'b1; wait_n(1);

        // R1 reset state
        rd(A_DIR, d); chk("R1 dir", d, '1);
        rd(A_DRV, d); chk("R1 drive", d, '0);
        rd(A_FLS, d); chk("R1 blink", d, '0);
        rd(A_INV, d); chk("R1 polarity", d, '0);
        rd(A_LAT, d); chk("R1 latch", d, '0);
        rd(A_LEN, d); chk("R1 edge en", d, '0);
        rd(A_VEN, d); chk("R1 level en", d, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 irq", 32'(irq), '0);

        // R2/R3 random register readback, pad_oe and non-blinking pad_out
        for (int i = 0; i < 8; i++) begin
            a = $urandom; b = $urandom; f = $urandom;
            wr(A_DRV, a); wr(A_DIR, b); wr(A_FLS, f);
            rd(A_DRV, d); chk("R2 drive rb", d, a);
            rd(A_DIR, d); chk("R2 dir rb", d, b);
            rd(A_FLS, d); chk("R2 blink rb", d, f);
            chk("R3 pad_oe", pad_oe, ~b);
            chk("R3 pad_out", pad_out & ~f, a & ~f);
        end
        wr(A_FLS, '0); wr(A_DIR, '1);

        // R2 sensed register ignores writes; unmapped offsets
        pad_in = '0; wr(A_INV, '0); wait_n(4);
        wr(A_SEN, '1); rd(A_SEN, d); chk("R2 sense write ignored", d, '0);
        wr(A_DRV, 32'h1234_5678);
        wr(6'h20, '1); wr(6'h02, '1);
        rd(6'h20, d); chk("R2 unmapped read", d, '0);
        rd(A_DRV, d); chk("R2 unmapped write no effect", d, 32'h1234_5678);
        rd(A_DIR, d); chk("R2 unmapped dir untouched", d, '1);

        // R4 synchroniser latency
        wr(A_INV, 32'h0000_00F0);
        pad_in = 32'h0000_0F00; wait_n(1);
        rd(A_SEN, d); chk("R4 not after first edge", d, 32'h0000_00F0);
        wait_n(1);
        rd(A_SEN, d); chk("R4 after second edge", d, 32'h0000_0FF0);

        // R5 falling edge with polarity 1 on pin 5
        wr(A_INV, 32'h20); pad_in = 32'h20; wait_n(5);
        wr(A_LAT, '0);
        pad_in = '0; wait_n(4);
        rd(A_LAT, d); chk("R5 falling edge pin5", d, 32'h20);
        wait_n(3);
        rd(A_LAT, d); chk("R5 latch sticky", d, 32'h20);

        // R6 keep bits written 1, clear bits written 0
        wr(A_INV, '0); pad_in = '0; wait_n(4);
        wr(A_LAT, '0);
        pad_in = 32'hF00F_0003; wait_n(4);
        wr(A_LAT, 32'h000F_0001);
        rd(A_LAT, d); chk("R6 selective clear", d, 32'h000F_0001);

        // R6 new edge coincides with clear
        wr(A_LAT, '0);
        pad_in = 32'hF00F_0083; wait_n(2);
        wr(A_LAT, '0);
        rd(A_LAT, d); chk("R6 edge wins over clear", d, 32'h80);

        // R5/R7/R8 random edge and level interrupts
        for (int i = 0; i < 30; i++) begin
            p = $urandom; a = $urandom; b = $urandom; m = $urandom; l = $urandom;
            if (i % 5 == 0) m = '0;
            if (i % 7 == 0) l = 32'h0100_0000;
            wr(A_LEN, '0); wr(A_VEN, '0);
            wr(A_INV, p); pad_in = a; wait_n(4);
            wr(A_LAT, '0); wr(A_LEN, m); wr(A_VEN, l);
            pad_in = b; wait_n(4);
            exp = ~(a ^ p) & (b ^ p);
            rd(A_SEN, d); chk("R4 sense random", d, b ^ p);
            rd(A_LAT, d); chk("R5 edge latch random", d, exp);
            chk("R7 R8 irq random", 32'(irq), 32'(grp_or(((b ^ p) & l) | (exp & m))));
        end

        // R8 single pin in the top group only
        wr(A_LEN, '0); wr(A_INV, '0); pad_in = 32'h8000_0000; wait_n(4);
        wr(A_VEN, 32'h8000_0000);
        chk("R8 top group only", 32'(irq), 32'(1 << (NGRP - 1)));
        wr(A_VEN, '0);
        chk("R7 level masked", 32'(irq), '0);

        // R9 blink on pin0 (drive 1), steady pin1, blink pin2 with drive 0
        wr(A_DIR, ~32'h7); wr(A_DRV, 32'h3); wr(A_FLS, 32'h5);
        chk("R3 outputs enabled", pad_oe, 32'h7);
        hi = 0;
        while (!(pad_out[0] == 1'b0)) begin wait_n(1); hi++; if (hi > 4*HALF) break; end
        lo = 0;
        while (!(pad_out[0] == 1'b1)) begin wait_n(1); lo++; if (lo > 4*HALF) break; end
        hi = 0;
        while (pad_out[0] == 1'b1 && hi <= 4*HALF) begin
            chk("R9 steady pin1", 32'(pad_out[1]), 1);
            chk("R9 blink with drive 0", 32'(pad_out[2]), 0);
            wait_n(1); hi++;
        end
        lo = 0;
        while (pad_out[0] == 1'b0 && lo <= 4*HALF) begin wait_n(1); lo++; end
        chk("R9 high half", hi, HALF);
        chk("R9 low half", lo, HALF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule